// File: doc/BRIEF.md
# Multiplexed Bus Write Cycle Generator

This block is a host-side master that turns a simple request/acknowledge transfer into a write cycle on a multiplexed address/data bus. The bus uses 68xx-style control: an address latch enable, an active-low chip select, an active-low data strobe and a direction line. The requester gives a small register address and a data byte. The block drives the address and pulses the latch enable. It then swaps the bus over to data, lowers the strobe and holds everything until the peripheral's hold minimums are met. Every minimum is written in nanoseconds and rounded up to whole system clock cycles.

Between strobes the peripheral needs a recovery gap, measured in arbitration clock periods. The arbitration period is the operating clock period, or twice that period when slow arbitration is selected. The normal gap is four periods. It grows to five when a write to the address-pointer-low register directly follows an access to the data register. The block remembers the last register it wrote. It holds off a pending request until the gap for that particular pair of accesses has run out.

Top module: `mbus_wr_seq`

## Requirements
- R1: While reset is asserted and after it is released with no request, ale_o is 0, cs_n_o is 1, ds_n_o is 1, dir_o is 0, bus_oe_o is 0 and ack_o is 0.
- R2: One clock after a request is accepted, ale_o, cs_n_o low, dir_o high (1 = write) and bus_oe_o all come up together. bus_ad_o carries the register address zero-extended into the low bits. ale_o stays high for the largest of the address setup, select setup and latch-high minimums, each rounded up to cycles.
- R3: After ale_o falls, the address stays on the bus for the larger of the address hold and select hold minimums in cycles, and the write byte follows. ds_n_o falls that hold plus a pre-strobe interval after ale_o falls. The pre-strobe interval is the largest of the latch-to-strobe, direction setup and latch-low minimums, minus the hold, and is at least one cycle.
- R4: ds_n_o stays low for the larger of the strobe-low and data setup minimums in cycles. During that time bus_ad_o holds the byte steadily, cs_n_o stays low and dir_o stays high.
- R5: After ds_n_o rises, the byte, cs_n_o low and dir_o high are held for the larger of the data hold and direction hold minimums in cycles. In the cycle after that, cs_n_o rises and ack_o is high for exactly one cycle.
- R6: Between two writes with no special pairing, the gap from one rising edge of ds_n_o to the next falling edge is 4 arbitration periods rounded up to cycles, and never less than the strobe-high minimum.
- R7: When the previous write went to the data register (address 4 by default) and the next goes to the address-pointer-low register (address 2 by default), the gap becomes 5 arbitration periods.
- R8: With slow_arb_i high, the arbitration period is twice the operating clock period, so both gaps double.
- R9: A write that follows a write to the address-pointer-low register uses the 4-period gap, whatever its target. So does a write to the pointer register that follows anything other than the data register.
- R10: The first write after reset waits for no gap. ds_n_o falls the latch-high, address-hold and pre-strobe intervals after ale_o rises, and ale_o rises one clock after the request is first seen.
- R11: While a cycle is in progress, changes on addr_i and data_i and a held req_i have no effect. The bus shows the values captured at acceptance, and exactly one address phase occurs per acknowledge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Write request, held until ack_o |
| addr_i | input | ADDR_W | Target register address |
| data_i | input | DATA_W | Byte to write |
| slow_arb_i | input | 1 | Doubles the arbitration period when high |
| ack_o | output | 1 | One-cycle pulse when the write has completed |
| bus_ad_o | output | DATA_W | Multiplexed address/data value |
| bus_oe_o | output | 1 | Drive enable for bus_ad_o |
| ale_o | output | 1 | Address latch enable, active high |
| cs_n_o | output | 1 | Chip select, active low |
| ds_n_o | output | 1 | Data strobe, active low |
| dir_o | output | 1 | Direction, high for write |

## Verification
A corrupted phase counter or a wrong state shows up within the same write cycle as a latch, strobe or hold width that is off by whole cycles, and the bench checks each width to the cycle. A stale or wrong remembered address does not show until the next request. It then appears as a recovery gap of the wrong length, 4 periods in place of 5 or the reverse, or undoubled in slow mode, measured from strobe rise to strobe fall. A capture register that follows the inputs during a cycle shows at once as a wrong address or byte on the bus after the inputs are scrambled mid-cycle.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AHOLD,
    ST_PRE,
    ST_STRB,
    ST_HOLD,
    ST_DONE
  } mbus_st_e;

  // nanoseconds rounded up to whole clock cycles
  function automatic int ns2cyc(input int ns, input int clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // recovery gap of a number of arbitration periods, in clock cycles
  function automatic int arb_gap_cyc(input int periods, input int opr_ns,
                                     input int clk_ns, input bit slow);
    return ns2cyc(periods * opr_ns * (slow ? 2 : 1), clk_ns);
  endfunction

endpackage

// File: rtl/mbus_phase_timer.sv
module mbus_phase_timer #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/mbus_gap_track.sv
module mbus_gap_track #(
  parameter int          ADDR_W    = 3,
  parameter int          GAP_W     = 6,
  parameter int          GAP_MAX   = 40,
  parameter int          LEAD      = 4,
  parameter int          G_NORM    = 16,
  parameter int          G_LONG    = 20,
  parameter int          G_NORM_S  = 32,
  parameter int          G_LONG_S  = 40,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 3'd4,
  parameter logic [ADDR_W-1:0] PTRL_ADDR = 3'd2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe_end,
  input  logic              accept,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [ADDR_W-1:0] next_addr,
  input  logic              slow,
  output logic              gap_ok,
  output logic [GAP_W-1:0]  gap_need
);

  localparam logic [GAP_W-1:0] CNT_SAT = GAP_W'(GAP_MAX);

  logic [GAP_W-1:0]  since_q;
  logic              seen_q;
  logic [ADDR_W-1:0] last_addr_q;
  logic              last_vld_q;
  logic              long_pair;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_q <= '0;
      seen_q  <= 1'b0;
    end else if (strobe_end) begin
      since_q <= '0;
      seen_q  <= 1'b1;
    end else if (since_q != CNT_SAT) begin
      since_q <= since_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_addr_q <= '0;
      last_vld_q  <= 1'b0;
    end else if (accept) begin
      last_addr_q <= acc_addr;
      last_vld_q  <= 1'b1;
    end
  end

  assign long_pair = last_vld_q && (last_addr_q == DATA_ADDR) && (next_addr == PTRL_ADDR);

  always_comb begin
    case ({slow, long_pair})
      2'b00:   gap_need = GAP_W'(G_NORM);
      2'b01:   gap_need = GAP_W'(G_LONG);
      2'b10:   gap_need = GAP_W'(G_NORM_S);
      default: gap_need = GAP_W'(G_LONG_S);
    endcase
  end

  // the strobe falls LEAD cycles after acceptance; one more cycle passes before it
  assign gap_ok = !seen_q || ((int'(since_q) + 1 + LEAD) >= int'(gap_need));

endmodule

// File: rtl/mbus_wr_seq.sv
module mbus_wr_seq
  import mbus_pkg::*;
#(
  parameter int ADDR_W        = 3,
  parameter int DATA_W        = 8,
  parameter int CLK_NS        = 10,
  parameter int OPR_NS        = 40,
  parameter int GAP_ARB       = 4,
  parameter int GAP_ARB_LONG  = 5,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 3'd4,
  parameter logic [ADDR_W-1:0] PTRL_ADDR = 3'd2,
  parameter int T_ADDR_SU_NS  = 20,
  parameter int T_ADDR_HD_NS  = 10,
  parameter int T_CS_SU_NS    = 10,
  parameter int T_CS_HD_NS    = 10,
  parameter int T_ALE_DS_NS   = 15,
  parameter int T_DATA_SU_NS  = 30,
  parameter int T_DATA_HD_NS  = 10,
  parameter int T_DIR_SU_NS   = 10,
  parameter int T_DIR_HD_NS   = 10,
  parameter int T_ALE_HI_NS   = 20,
  parameter int T_ALE_LO_NS   = 20,
  parameter int T_DS_LO_NS    = 20,
  parameter int T_DS_HI_NS    = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              slow_arb_i,
  output logic              ack_o,
  output logic [DATA_W-1:0] bus_ad_o,
  output logic              bus_oe_o,
  output logic              ale_o,
  output logic              cs_n_o,
  output logic              ds_n_o,
  output logic              dir_o
);

  // phase lengths in cycles
  localparam int N_ASU = imax(1, imax(ns2cyc(T_ADDR_SU_NS, CLK_NS),
                             imax(ns2cyc(T_CS_SU_NS, CLK_NS), ns2cyc(T_ALE_HI_NS, CLK_NS))));
  localparam int N_AH  = imax(1, imax(ns2cyc(T_ADDR_HD_NS, CLK_NS), ns2cyc(T_CS_HD_NS, CLK_NS)));
  localparam int N_PRE = imax(1, imax(ns2cyc(T_ALE_DS_NS, CLK_NS),
                             imax(ns2cyc(T_DIR_SU_NS, CLK_NS), ns2cyc(T_ALE_LO_NS, CLK_NS))) - N_AH);
  localparam int N_DSL = imax(1, imax(ns2cyc(T_DS_LO_NS, CLK_NS), ns2cyc(T_DATA_SU_NS, CLK_NS)));
  localparam int N_DH  = imax(1, imax(ns2cyc(T_DATA_HD_NS, CLK_NS), ns2cyc(T_DIR_HD_NS, CLK_NS)));
  localparam int LEAD  = N_ASU + N_AH + N_PRE;

  // recovery gaps in cycles
  localparam int N_DSH    = ns2cyc(T_DS_HI_NS, CLK_NS);
  localparam int G_NORM   = imax(N_DSH, arb_gap_cyc(GAP_ARB, OPR_NS, CLK_NS, 1'b0));
  localparam int G_LONG   = imax(N_DSH, arb_gap_cyc(GAP_ARB_LONG, OPR_NS, CLK_NS, 1'b0));
  localparam int G_NORM_S = imax(N_DSH, arb_gap_cyc(GAP_ARB, OPR_NS, CLK_NS, 1'b1));
  localparam int G_LONG_S = imax(N_DSH, arb_gap_cyc(GAP_ARB_LONG, OPR_NS, CLK_NS, 1'b1));
  localparam int GAP_MAX  = imax(imax(G_NORM, G_LONG), imax(G_NORM_S, G_LONG_S));
  localparam int GAP_W    = $clog2(GAP_MAX + 1);

  localparam int PH_MAX = imax(imax(N_ASU, N_AH), imax(N_PRE, imax(N_DSL, N_DH)));
  localparam int PH_W   = imax(1, $clog2(PH_MAX));

  localparam logic [PH_W-1:0] L_ASU = PH_W'(N_ASU - 1);
  localparam logic [PH_W-1:0] L_AH  = PH_W'(N_AH - 1);
  localparam logic [PH_W-1:0] L_PRE = PH_W'(N_PRE - 1);
  localparam logic [PH_W-1:0] L_DSL = PH_W'(N_DSL - 1);
  localparam logic [PH_W-1:0] L_DH  = PH_W'(N_DH - 1);

  mbus_st_e          state_q, state_d;
  logic [ADDR_W-1:0] lat_addr_q;
  logic [DATA_W-1:0] lat_data_q;

  // named internal events
  logic              accept_evt;
  logic              phase_done;
  logic              strobe_end_evt;
  logic              gap_ok;
  logic [GAP_W-1:0]  gap_need;
  logic              tmr_load;
  logic [PH_W-1:0]   tmr_val;

  mbus_phase_timer #(.CNT_W(PH_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (phase_done)
  );

  mbus_gap_track #(
    .ADDR_W    (ADDR_W),
    .GAP_W     (GAP_W),
    .GAP_MAX   (GAP_MAX),
    .LEAD      (LEAD),
    .G_NORM    (G_NORM),
    .G_LONG    (G_LONG),
    .G_NORM_S  (G_NORM_S),
    .G_LONG_S  (G_LONG_S),
    .DATA_ADDR (DATA_ADDR),
    .PTRL_ADDR (PTRL_ADDR)
  ) u_gap (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe_end (strobe_end_evt),
    .accept     (accept_evt),
    .acc_addr   (addr_i),
    .next_addr  (addr_i),
    .slow       (slow_arb_i),
    .gap_ok     (gap_ok),
    .gap_need   (gap_need)
  );

  assign accept_evt     = (state_q == ST_IDLE) && req_i && gap_ok;
  assign strobe_end_evt = (state_q == ST_STRB) && phase_done;

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    case (state_q)
      ST_IDLE: if (accept_evt) begin
        state_d = ST_ADDR;  tmr_load = 1'b1; tmr_val = L_ASU;
      end
      ST_ADDR: if (phase_done) begin
        state_d = ST_AHOLD; tmr_load = 1'b1; tmr_val = L_AH;
      end
      ST_AHOLD: if (phase_done) begin
        state_d = ST_PRE;   tmr_load = 1'b1; tmr_val = L_PRE;
      end
      ST_PRE: if (phase_done) begin
        state_d = ST_STRB;  tmr_load = 1'b1; tmr_val = L_DSL;
      end
      ST_STRB: if (phase_done) begin
        state_d = ST_HOLD;  tmr_load = 1'b1; tmr_val = L_DH;
      end
      ST_HOLD: if (phase_done) state_d = ST_DONE;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      lat_addr_q <= '0;
      lat_data_q <= '0;
    end else begin
      state_q <= state_d;
      if (accept_evt) begin
        lat_addr_q <= addr_i;
        lat_data_q <= data_i;
      end
    end
  end

  // bus pins decoded from the registered state
  logic in_cycle;
  assign in_cycle = (state_q == ST_ADDR) || (state_q == ST_AHOLD) || (state_q == ST_PRE)
                 || (state_q == ST_STRB) || (state_q == ST_HOLD);

  always_comb begin
    if ((state_q == ST_ADDR) || (state_q == ST_AHOLD)) begin
      bus_ad_o = DATA_W'(lat_addr_q);
    end else if (in_cycle) begin
      bus_ad_o = lat_data_q;
    end else begin
      bus_ad_o = '0;
    end
  end

  assign bus_oe_o = in_cycle;
  assign cs_n_o   = !in_cycle;
  assign dir_o    = in_cycle;
  assign ale_o    = (state_q == ST_ADDR);
  assign ds_n_o   = (state_q != ST_STRB);
  assign ack_o    = (state_q == ST_DONE);

endmodule

// File: rtl/mbus_wr_seq_chk.sv
module mbus_wr_seq_chk #(
  parameter int DATA_W  = 8,
  parameter int MIN_GAP = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ale_o,
  input logic              cs_n_o,
  input logic              ds_n_o,
  input logic              dir_o,
  input logic              ack_o,
  input logic [DATA_W-1:0] bus_ad_o,
  input logic              accept_evt
);

  localparam int HW = $clog2(MIN_GAP + 2);

  logic          ds_q;
  logic          rose_seen_q;
  logic [HW-1:0] hi_cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ds_q        <= 1'b1;
      rose_seen_q <= 1'b0;
      hi_cnt_q    <= '0;
    end else begin
      ds_q <= ds_n_o;
      if (ds_n_o && !ds_q) begin
        hi_cnt_q    <= HW'(1);
        rose_seen_q <= 1'b1;
      end else if (ds_n_o && (hi_cnt_q != HW'(MIN_GAP + 1))) begin
        hi_cnt_q <= hi_cnt_q + 1'b1;
      end
    end
  end

  // R2: latch enable only with chip selected
  a_r2_ale_selected: assert property (@(posedge clk) disable iff (!rst_n)
    ale_o |-> (!cs_n_o && dir_o));

  // R3: address still on the bus in the cycle ale falls
  a_r3_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ale_o) |-> $stable(bus_ad_o));

  // R4: strobe only inside a selected write cycle, data steady while low
  a_r4_strobe_framed: assert property (@(posedge clk) disable iff (!rst_n)
    !ds_n_o |-> (!cs_n_o && dir_o && !ale_o));

  a_r4_data_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (!ds_n_o && $past(!ds_n_o)) |-> $stable(bus_ad_o));

  // R5: acknowledge is a single cycle pulse after deselect
  a_r5_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |=> !ack_o);

  a_r5_ack_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> (cs_n_o && ds_n_o));

  // R6: strobe high never shorter than the normal recovery gap
  a_r6_min_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (rose_seen_q && !ds_n_o && ds_q) |-> (int'(hi_cnt_q) >= MIN_GAP));

  // R11: requests taken only between cycles
  a_r11_accept_idle: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |-> (cs_n_o && !ack_o));

  a_r11_ale_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ale_o) |-> $past(cs_n_o));

endmodule

bind mbus_wr_seq mbus_wr_seq_chk #(
  .DATA_W  (DATA_W),
  .MIN_GAP (G_NORM)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ale_o      (ale_o),
  .cs_n_o     (cs_n_o),
  .ds_n_o     (ds_n_o),
  .dir_o      (dir_o),
  .ack_o      (ack_o),
  .bus_ad_o   (bus_ad_o),
  .accept_evt (accept_evt)
);

// File: tb/mbus_wr_seq_bench.sv
module mbus_wr_seq_bench;

  localparam int CLK = 8;
  localparam int OPR = 40;

  function automatic int up(input int ns);
    int c;
    c = ns / CLK;
    if (c * CLK < ns) c = c + 1;
    return c;
  endfunction

  function automatic int mx(input int a, input int b);
    if (a > b) return a;
    return b;
  endfunction

  // expected widths from the requirement text
  localparam int E_ALE_HI = mx(mx(up(20), up(10)), up(20));      // R2
  localparam int E_AHOLD  = mx(up(10), up(10));                  // R3
  localparam int E_PRE    = mx(1, mx(mx(up(15), up(10)), up(20)) - E_AHOLD);
  localparam int E_DS_LO  = mx(up(20), up(30));                  // R4
  localparam int E_DHOLD  = mx(up(10), up(10));                  // R5
  localparam int E_G4     = mx(up(20), up(4 * OPR));             // R6
  localparam int E_G5     = mx(up(20), up(5 * OPR));             // R7
  localparam int E_G4S    = mx(up(20), up(8 * OPR));             // R8
  localparam int E_G5S    = mx(up(20), up(10 * OPR));            // R8

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_i = 1'b0;
  logic [2:0] addr_i = '0;
  logic [7:0] data_i = '0;
  logic       slow_arb_i = 1'b0;
  logic       ack_o, bus_oe_o, ale_o, cs_n_o, ds_n_o, dir_o;
  logic [7:0] bus_ad_o;

  always #(CLK / 2) clk = ~clk;

  mbus_wr_seq #(.CLK_NS(CLK), .OPR_NS(OPR)) u_mbus_wr_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_i      (req_i),
    .addr_i     (addr_i),
    .data_i     (data_i),
    .slow_arb_i (slow_arb_i),
    .ack_o      (ack_o),
    .bus_ad_o   (bus_ad_o),
    .bus_oe_o   (bus_oe_o),
    .ale_o      (ale_o),
    .cs_n_o     (cs_n_o),
    .ds_n_o     (ds_n_o),
    .dir_o      (dir_o)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // port monitor, sampled at the falling edge
  logic ale_q = 1'b0, ds_q = 1'b1, cs_q = 1'b1;
  int   ale_rise, ale_fall, ds_fall, ds_rise, cs_rise, ack_cyc;
  int   n_ale = 0, gap_meas = -1, ack_run = 0, ack_run_max = 0;
  bit   have_rise = 1'b0, data_moved = 1'b0, frame_bad = 1'b0;
  logic [7:0] addr_hi, addr_after, data_lo, data_after;
  logic cs_after, dir_after;

  always @(negedge clk) begin
    if (rst_n) begin
      if (ale_o && !ale_q) begin ale_rise = cyc; n_ale = n_ale + 1; end
      if (ale_o) addr_hi = bus_ad_o;
      if (!ale_o && ale_q) begin ale_fall = cyc; addr_after = bus_ad_o; end
      if (!ds_n_o && ds_q) begin
        gap_meas   = have_rise ? (cyc - ds_rise) : -1;
        ds_fall    = cyc;
        data_lo    = bus_ad_o;
        data_moved = 1'b0;
        frame_bad  = 1'b0;
      end
      if (!ds_n_o) begin
        if (bus_ad_o != data_lo) data_moved = 1'b1;
        if (cs_n_o || !dir_o || ale_o) frame_bad = 1'b1;
      end
      if (ds_n_o && !ds_q) begin
        ds_rise    = cyc;
        have_rise  = 1'b1;
        data_after = bus_ad_o;
        cs_after   = cs_n_o;
        dir_after  = dir_o;
      end
      if (cs_n_o && !cs_q) cs_rise = cyc;
      if (ack_o) begin
        ack_cyc = cyc;
        ack_run = ack_run + 1;
        if (ack_run > ack_run_max) ack_run_max = ack_run;
      end else begin
        ack_run = 0;
      end
    end
    ale_q = ale_o;
    ds_q  = ds_n_o;
    cs_q  = cs_n_o;
  end

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk = n_chk + 1;
    if (act != exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  // one write, with its own shape and gap checks
  task automatic write_chk(input logic [2:0] a, input logic [7:0] d, input bit slow,
                           input int exp_gap, input string gtag, input bit first);
    int ale0, req_cyc;
    ale0       = n_ale;
    req_cyc    = cyc;
    req_i      = 1'b1;
    addr_i     = a;
    data_i     = d;
    slow_arb_i = slow;
    while (n_ale == ale0) tick();
    addr_i = ~a;      // R11: scramble inputs mid-cycle
    data_i = ~d;
    while (!ack_o) tick();
    req_i = 1'b0;
    chk("R2", "ale high cycles", ale_fall - ale_rise, E_ALE_HI);
    chk("R2", "address in latch phase", int'(addr_hi), int'({5'd0, a}));
    chk("R3", "address after ale falls", int'(addr_after), int'({5'd0, a}));
    chk("R3", "ale fall to strobe fall", ds_fall - ale_fall, E_AHOLD + E_PRE);
    chk("R4", "strobe low cycles", ds_rise - ds_fall, E_DS_LO);
    chk("R4", "byte while strobe low", int'(data_lo), int'(d));
    chk("R4", "byte moved or frame broken", int'(data_moved | frame_bad), 0);
    chk("R5", "byte and select after strobe", int'({data_after, cs_after, dir_after}),
        int'({d, 1'b0, 1'b1}));
    chk("R5", "strobe rise to deselect", cs_rise - ds_rise, E_DHOLD);
    chk("R5", "ack cycle", ack_cyc, cs_rise);
    chk("R11", "address phases this write", n_ale - ale0, 1);
    if (first) begin
      chk("R10", "request to ale rise", ale_rise - req_cyc, 1);
      chk("R10", "ale rise to strobe fall", ds_fall - ale_rise, E_ALE_HI + E_AHOLD + E_PRE);
    end else begin
      chk(gtag, "recovery gap", gap_meas, exp_gap);
    end
  endtask

  task automatic t_reset();
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "outputs in reset", int'({ale_o, cs_n_o, ds_n_o, dir_o, bus_oe_o, ack_o}), 6'b011000);
    tick();
    rst_n = 1'b1;
    repeat (3) tick();
    chk("R1", "outputs after reset", int'({ale_o, cs_n_o, ds_n_o, dir_o, bus_oe_o, ack_o}), 6'b011000);
  endtask

  task automatic t_normal_pairs();
    write_chk(3'd1, 8'hA5, 1'b0, 0, "R10", 1'b1);
    write_chk(3'd3, 8'h3C, 1'b0, E_G4, "R6", 1'b0);
    write_chk(3'd4, 8'h81, 1'b0, E_G4, "R6", 1'b0);
  endtask

  task automatic t_data_then_ptr();
    write_chk(3'd2, 8'h5A, 1'b0, E_G5, "R7", 1'b0);
    write_chk(3'd4, 8'hFF, 1'b0, E_G4, "R9", 1'b0);
    write_chk(3'd2, 8'h00, 1'b0, E_G5, "R7", 1'b0);
  endtask

  task automatic t_after_ptr();
    write_chk(3'd2, 8'h11, 1'b0, E_G4, "R9", 1'b0);
    write_chk(3'd3, 8'h22, 1'b0, E_G4, "R9", 1'b0);
    write_chk(3'd2, 8'h33, 1'b0, E_G4, "R9", 1'b0);
  endtask

  task automatic t_slow();
    write_chk(3'd6, 8'hC3, 1'b1, E_G4S, "R8", 1'b0);
    write_chk(3'd4, 8'h96, 1'b1, E_G4S, "R8", 1'b0);
    write_chk(3'd2, 8'h69, 1'b1, E_G5S, "R8", 1'b0);
    write_chk(3'd7, 8'h0F, 1'b0, E_G4, "R6", 1'b0);
  endtask

  initial begin
    t_reset();
    t_normal_pairs();
    t_data_then_ptr();
    t_after_ptr();
    t_slow();
    repeat (4) tick();
    chk("R5", "longest ack run", ack_run_max, 1);
    chk("R1", "idle after traffic", int'({ale_o, cs_n_o, ds_n_o, bus_oe_o}), 4'b0110);
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail = n_fail + 1;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

endmodule